// File: doc/BRIEF.md
# Display register command-stream executor

The block runs a list of commands held in a word-addressed instruction memory and turns them into writes on a simple register bus. Software fills the memory with 64-bit instructions and programs a head pointer. With the enable level high, it then writes the tail pointer. The engine fetches every instruction from head up to tail and executes each one in turn, and it holds a busy flag until its fetch pointer reaches the tail.

Each instruction is two 32-bit words: the low word first, then the high word. Opcode bits 31:24 of the high word choose the meaning of the low word. The instruction can be a single register write with byte enables, a counted burst of data words to one register, a wait for a number of 1-microsecond ticks or vertical-blank pulses, a completion interrupt, or a no-op. Waits on the scanline window and register polls are passed to companion blocks through a start/done handshake. A halt input stops the engine at once.

Top module: `cmdq_exec`

## Requirements
- R1: After reset, busy, prog_done and err_flag are 0, fetch_ptr is 0 and no bus write or companion start is issued.
- R2: While idle, a pulse on ctl_tail_wr with ctl_enable high loads fetch_ptr from ctl_head and latches ctl_tail, and busy reads 1 in the next cycle. With ctl_enable low the pulse is ignored: busy and fetch_ptr are unchanged. If head equals tail, no run starts.
- R3: Opcode 0x01 issues exactly one bus write. Its offset is high-word bits 19:0, its byte enables are high-word bits 23:20 (bit n enables data byte n), and its data is the low word.
- R4: Opcode 0x09 takes the low word as a count N and writes the next N memory words, in order, to the offset in high-word bits 19:0, with all four byte enables set. If N is odd, the following pad word is skipped without being written. N = 0 writes nothing.
- R5: Opcode 0x00 produces no bus write and moves on to the next instruction.
- R6: Opcode 0x02 holds off the next instruction until at least as many us_tick pulses as the low word have occurred. A low word of 0 adds no wait.
- R7: Opcode 0x04 holds off the next instruction until at least as many vblank pulses as the low word have occurred.
- R8: Opcode 0x07 sets prog_done. prog_done stays 1 until a pulse on irq_clr, and a set in the same cycle as a clear wins.
- R9: Opcodes 0x03, 0x05, 0x06 and 0x0A raise ext_start for one cycle, carrying the opcode on ext_op, the low word on ext_lo and high-word bits 23:0 on ext_hi. The engine does not move on until ext_done.
- R10: Any other opcode acts as a no-op and sets err_flag, which stays 1 until reset.
- R11: busy stays 1 until the fetch pointer equals the latched tail. The engine then returns to idle with fetch_ptr equal to tail.
- R12: A pulse on ctl_halt makes busy 0 in the next cycle, and no further bus write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Enable level that gates a start |
| ctl_head | input | AW | Head word address of the program |
| ctl_tail | input | AW | Tail word address (one past the last word) |
| ctl_tail_wr | input | 1 | Tail write strobe; starts a run when enabled and idle |
| ctl_halt | input | 1 | Stop execution and return to idle |
| irq_clr | input | 1 | Write-one-to-clear strobe for prog_done |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| vblank | input | 1 | One-cycle pulse per vertical blank |
| mem_rd | output | 1 | Instruction memory read strobe |
| mem_addr | output | AW | Instruction memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| rb_we | output | 1 | Register bus write strobe |
| rb_addr | output | 20 | Register offset |
| rb_be | output | 4 | Byte enables |
| rb_wdata | output | 32 | Write data |
| ext_start | output | 1 | Start pulse to a companion block |
| ext_op | output | 8 | Opcode handed to the companion |
| ext_lo | output | 32 | Low word handed to the companion |
| ext_hi | output | 24 | High-word bits 23:0 handed to the companion |
| ext_done | input | 1 | Companion completion pulse |
| busy | output | 1 | Engine running |
| prog_done | output | 1 | Sticky program-done status |
| err_flag | output | 1 | Sticky unknown-opcode flag |
| fetch_ptr | output | AW | Current fetch word address |

## Verification
The assertions check, on every cycle, the rules that never depend on program content. No fetch or write happens outside a run, a halt always drops busy, prog_done and err_flag only clear the way they should, ext_start lasts a single cycle, and the pointer stays put while idle. Only the bench scenarios can show that decoding is correct: the offsets, byte enables and data of each write, the order of burst words and the skipped pad, that waits last at least the requested number of ticks or blanks, that the engine stalls on the companion handshake, and that the pointer finishes exactly on the tail.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int REG_OFS_W = 20;
    localparam int BE_W      = 4;
    localparam int WORD_W    = 32;
    localparam int OP_MSB    = 31;
    localparam int OP_LSB    = 24;
    localparam int BE_LSB    = 20;

    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_WRITE   = 8'h01;
    localparam logic [7:0] OP_WAIT_US = 8'h02;
    localparam logic [7:0] OP_SCAN    = 8'h03;
    localparam logic [7:0] OP_WAIT_VB = 8'h04;
    localparam logic [7:0] OP_SCAN_IN = 8'h05;
    localparam logic [7:0] OP_SCAN_OU = 8'h06;
    localparam logic [7:0] OP_IRQ     = 8'h07;
    localparam logic [7:0] OP_BURST   = 8'h09;
    localparam logic [7:0] OP_POLL    = 8'h0A;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_EXEC,
        ST_WAIT_US,
        ST_WAIT_VB,
        ST_BURST_RD,
        ST_BURST_WR,
        ST_EXT
    } state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_WRITE,
        K_WAIT_US,
        K_WAIT_VB,
        K_IRQ,
        K_BURST,
        K_EXT,
        K_BAD
    } kind_e;

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [7:0] opcode,
    output kind_e      kind
);

    always_comb begin
        unique case (opcode)
            OP_NOP:     kind = K_NOP;
            OP_WRITE:   kind = K_WRITE;
            OP_WAIT_US: kind = K_WAIT_US;
            OP_WAIT_VB: kind = K_WAIT_VB;
            OP_IRQ:     kind = K_IRQ;
            OP_BURST:   kind = K_BURST;
            OP_SCAN,
            OP_SCAN_IN,
            OP_SCAN_OU,
            OP_POLL:    kind = K_EXT;
            default:    kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/cmdq_countdown.sv
module cmdq_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
    import cmdq_pkg::*;
#(
    parameter int AW    = 10,
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_enable,
    input  logic [AW-1:0]        ctl_head,
    input  logic [AW-1:0]        ctl_tail,
    input  logic                 ctl_tail_wr,
    input  logic                 ctl_halt,
    input  logic                 irq_clr,
    input  logic                 us_tick,
    input  logic                 vblank,
    output logic                 mem_rd,
    output logic [AW-1:0]        mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 rb_we,
    output logic [REG_OFS_W-1:0] rb_addr,
    output logic [BE_W-1:0]      rb_be,
    output logic [WORD_W-1:0]    rb_wdata,
    output logic                 ext_start,
    output logic [7:0]           ext_op,
    output logic [WORD_W-1:0]    ext_lo,
    output logic [OP_LSB-1:0]    ext_hi,
    input  logic                 ext_done,
    output logic                 busy,
    output logic                 prog_done,
    output logic                 err_flag,
    output logic [AW-1:0]        fetch_ptr
);

    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    typedef struct packed {
        state_e                 state;
        logic [AW-1:0]          ptr;
        logic [AW-1:0]          tail;
        logic [WORD_W-1:0]      lo;
        logic [WORD_W-1:0]      hi;
        logic                   done;
        logic                   err;
        logic                   wr;
        logic [REG_OFS_W-1:0]   waddr;
        logic [BE_W-1:0]        wbe;
        logic [WORD_W-1:0]      wdata;
        logic                   xs;
        logic [7:0]             xop;
        logic [WORD_W-1:0]      xlo;
        logic [OP_LSB-1:0]      xhi;
    } regs_t;

    regs_t r_d, r_q;

    kind_e            kind;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic [AW-1:0]    ptr_skip;

    cmdq_decode u_decode (
        .opcode (mem_rdata[OP_MSB:OP_LSB]),
        .kind   (kind)
    );

    cmdq_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero)
    );

    function automatic state_e after(input logic [AW-1:0] p, input logic [AW-1:0] t);
        return (p == t) ? ST_IDLE : ST_RD_LO;
    endfunction

    assign cnt_val  = r_q.lo[CNT_W-1:0];
    assign ptr_skip = r_q.ptr + AW'(r_q.ptr[0]);

    always_comb begin
        r_d      = r_q;
        r_d.wr   = 1'b0;
        r_d.xs   = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        mem_rd   = 1'b0;
        mem_addr = r_q.ptr;

        if (irq_clr) begin
            r_d.done = 1'b0;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (ctl_tail_wr && ctl_enable) begin
                    r_d.ptr   = ctl_head;
                    r_d.tail  = ctl_tail;
                    r_d.state = after(ctl_head, ctl_tail);
                end
            end
            ST_RD_LO: begin
                mem_rd    = 1'b1;
                r_d.ptr   = r_q.ptr + PTR_ONE;
                r_d.state = ST_RD_HI;
            end
            ST_RD_HI: begin
                mem_rd    = 1'b1;
                r_d.ptr   = r_q.ptr + PTR_ONE;
                r_d.lo    = mem_rdata;
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.hi    = mem_rdata;
                r_d.state = after(r_q.ptr, r_q.tail);
                unique case (kind)
                    K_NOP: ;
                    K_BAD: r_d.err = 1'b1;
                    K_WRITE: begin
                        r_d.wr    = 1'b1;
                        r_d.waddr = mem_rdata[REG_OFS_W-1:0];
                        r_d.wbe   = mem_rdata[BE_LSB+BE_W-1:BE_LSB];
                        r_d.wdata = r_q.lo;
                    end
                    K_WAIT_US: begin
                        cnt_load  = 1'b1;
                        r_d.state = ST_WAIT_US;
                    end
                    K_WAIT_VB: begin
                        cnt_load  = 1'b1;
                        r_d.state = ST_WAIT_VB;
                    end
                    K_IRQ: r_d.done = 1'b1;
                    K_BURST: begin
                        cnt_load  = 1'b1;
                        r_d.state = ST_BURST_RD;
                    end
                    K_EXT: begin
                        r_d.xs    = 1'b1;
                        r_d.xop   = mem_rdata[OP_MSB:OP_LSB];
                        r_d.xlo   = r_q.lo;
                        r_d.xhi   = mem_rdata[OP_LSB-1:0];
                        r_d.state = ST_EXT;
                    end
                    default: ;
                endcase
            end
            ST_WAIT_US: begin
                if (cnt_zero) begin
                    r_d.state = after(r_q.ptr, r_q.tail);
                end else begin
                    cnt_dec = us_tick;
                end
            end
            ST_WAIT_VB: begin
                if (cnt_zero) begin
                    r_d.state = after(r_q.ptr, r_q.tail);
                end else begin
                    cnt_dec = vblank;
                end
            end
            ST_BURST_RD: begin
                if (cnt_zero) begin
                    r_d.ptr   = ptr_skip;
                    r_d.state = after(ptr_skip, r_q.tail);
                end else begin
                    mem_rd    = 1'b1;
                    r_d.ptr   = r_q.ptr + PTR_ONE;
                    r_d.state = ST_BURST_WR;
                end
            end
            ST_BURST_WR: begin
                r_d.wr    = 1'b1;
                r_d.waddr = r_q.hi[REG_OFS_W-1:0];
                r_d.wbe   = {BE_W{1'b1}};
                r_d.wdata = mem_rdata;
                cnt_dec   = 1'b1;
                r_d.state = ST_BURST_RD;
            end
            ST_EXT: begin
                if (ext_done) begin
                    r_d.state = after(r_q.ptr, r_q.tail);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (ctl_halt) begin
            r_d.state = ST_IDLE;
            r_d.wr    = 1'b0;
            r_d.xs    = 1'b0;
            mem_rd    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rb_we     = r_q.wr;
    assign rb_addr   = r_q.waddr;
    assign rb_be     = r_q.wbe;
    assign rb_wdata  = r_q.wdata;
    assign ext_start = r_q.xs;
    assign ext_op    = r_q.xop;
    assign ext_lo    = r_q.xlo;
    assign ext_hi    = r_q.xhi;
    assign busy      = (r_q.state != ST_IDLE);
    assign prog_done = r_q.done;
    assign err_flag  = r_q.err;
    assign fetch_ptr = r_q.ptr;

endmodule

// File: rtl/cmdq_exec_chk.sv
module cmdq_exec_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_rd,
    input logic          rb_we,
    input logic          ctl_halt,
    input logic          ctl_tail_wr,
    input logic          irq_clr,
    input logic          prog_done,
    input logic          ext_start,
    input logic          err_flag,
    input logic [AW-1:0] fetch_ptr
);

    AST_NO_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd) else $error("fetch while idle"); // R11

    AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |-> $past(busy)) else $error("write outside a run"); // R3

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_halt |=> (!busy && !rb_we)) else $error("halt ignored"); // R12

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && !irq_clr) |=> prog_done) else $error("done lost"); // R8

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_done) |-> $past(irq_clr)) else $error("done cleared without strobe"); // R8

    AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |=> !ext_start) else $error("start longer than one cycle"); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag) else $error("error flag dropped"); // R10

    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctl_tail_wr) |=> $stable(fetch_ptr)) else $error("pointer moved while idle"); // R2

endmodule

bind cmdq_exec cmdq_exec_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_rd      (mem_rd),
    .rb_we       (rb_we),
    .ctl_halt    (ctl_halt),
    .ctl_tail_wr (ctl_tail_wr),
    .irq_clr     (irq_clr),
    .prog_done   (prog_done),
    .ext_start   (ext_start),
    .err_flag    (err_flag),
    .fetch_ptr   (fetch_ptr)
);

// File: tb/tb_cmdq_exec.sv
`timescale 1ns/1ps
module tb_cmdq_exec;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctl_enable, ctl_tail_wr, ctl_halt, irq_clr;
    logic [AW-1:0] ctl_head, ctl_tail;
    logic          us_tick, vblank, ext_done;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          rb_we;
    logic [19:0]   rb_addr;
    logic [3:0]    rb_be;
    logic [31:0]   rb_wdata;
    logic          ext_start;
    logic [7:0]    ext_op;
    logic [31:0]   ext_lo;
    logic [23:0]   ext_hi;
    logic          busy, prog_done, err_flag;
    logic [AW-1:0] fetch_ptr;

    logic [31:0] mem [0:DEPTH-1];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_cnt = 0;
    int vb_cnt = 0;
    int tdiv = 0;
    int xdly = 0;
    int ext_seen = 0;
    int done_cyc = 0;
    bit finished = 0;

    logic [55:0] exp_q[$];
    int wr_cyc_q[$];
    int wr_tick_q[$];
    int wr_vb_q[$];
    logic [7:0]  exp_xop;
    logic [31:0] exp_xlo;
    logic [23:0] exp_xhi;

    always #2.5 clk = ~clk;

    cmdq_exec #(.AW(AW), .CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_head(ctl_head),
        .ctl_tail(ctl_tail), .ctl_tail_wr(ctl_tail_wr), .ctl_halt(ctl_halt),
        .irq_clr(irq_clr), .us_tick(us_tick), .vblank(vblank), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rb_we(rb_we), .rb_addr(rb_addr),
        .rb_be(rb_be), .rb_wdata(rb_wdata), .ext_start(ext_start), .ext_op(ext_op),
        .ext_lo(ext_lo), .ext_hi(ext_hi), .ext_done(ext_done), .busy(busy),
        .prog_done(prog_done), .err_flag(err_flag), .fetch_ptr(fetch_ptr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // tick and blank sources
    always @(negedge clk) begin
        tdiv++;
        us_tick = (tdiv % 4 == 0);
        vblank  = (tdiv % 16 == 0);
        if (us_tick) tick_cnt++;
        if (vblank) vb_cnt++;
    end

    // reference comparison of the bus on every clock
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rb_we === 1'b1) begin
            wr_cyc_q.push_back(cyc);
            wr_tick_q.push_back(tick_cnt);
            wr_vb_q.push_back(vb_cnt);
            if (exp_q.size() == 0) begin
                chk(0, "unexpected bus write (R3 R4 R5 R12)", {rb_addr, rb_be, rb_wdata}, 0);
            end else begin
                logic [55:0] e;
                e = exp_q.pop_front();
                chk({rb_addr, rb_be, rb_wdata} == e, "bus write (R3 R4)", {rb_addr, rb_be, rb_wdata}, e);
            end
        end
    end

    // companion responder
    always @(negedge clk) begin
        ext_done = 1'b0;
        if (xdly > 0) begin
            xdly--;
            if (xdly == 0) begin
                ext_done = 1'b1;
                done_cyc = cyc;
            end
        end
        if (rst_n === 1'b1 && ext_start === 1'b1) begin
            ext_seen++;
            chk(ext_op == exp_xop, "R9 ext_op", ext_op, exp_xop);
            chk(ext_lo == exp_xlo, "R9 ext_lo", ext_lo, exp_xlo);
            chk(ext_hi == exp_xhi, "R9 ext_hi", ext_hi, exp_xhi);
            xdly = 6;
        end
    end

    task automatic put(input int a, input logic [31:0] lo, input logic [31:0] hi);
        mem[a]   = lo;
        mem[a+1] = hi;
    endtask

    task automatic expect_wr(input logic [19:0] a, input logic [3:0] be, input logic [31:0] d);
        exp_q.push_back({a, be, d});
    endtask

    task automatic clear_stamps();
        wr_cyc_q.delete();
        wr_tick_q.delete();
        wr_vb_q.delete();
    endtask

    task automatic start(input int h, input int t, input bit en);
        @(negedge clk);
        ctl_head    = AW'(h);
        ctl_tail    = AW'(t);
        ctl_enable  = en;
        ctl_tail_wr = 1'b1;
        @(negedge clk);
        ctl_tail_wr = 1'b0;
    endtask

    task automatic finish_run(input int t, input string tag);
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(!busy, {tag, " R11 busy clears"}, busy, 0);
        chk(fetch_ptr == AW'(t), {tag, " R11 fetch_ptr at tail"}, fetch_ptr, t);
        chk(exp_q.size() == 0, {tag, " R11 all writes seen"}, exp_q.size(), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
        rst_n = 1'b0; ctl_enable = 1'b0; ctl_tail_wr = 1'b0; ctl_halt = 1'b0;
        irq_clr = 1'b0; ctl_head = '0; ctl_tail = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", busy, 0);
        chk(!prog_done, "R1 prog_done", prog_done, 0);
        chk(!err_flag, "R1 err_flag", err_flag, 0);
        chk(fetch_ptr == 0, "R1 fetch_ptr", fetch_ptr, 0);
        chk(!rb_we && !ext_start, "R1 no activity", {rb_we, ext_start}, 0);

        // R3 R5: no-op then two single writes
        put(0, 32'h0, 32'h0000_0000);
        put(2, 32'hDEAD_BEEF, 32'h01F0_0123);
        put(4, 32'h1122_3344, 32'h0150_0456);
        expect_wr(20'h00123, 4'hF, 32'hDEAD_BEEF);
        expect_wr(20'h00456, 4'h5, 32'h1122_3344);
        start(0, 6, 1);
        chk(busy, "R2 busy one cycle after start", busy, 1);
        finish_run(6, "single");

        // R4 bursts: odd with pad, even, zero length
        put(16, 32'd3, 32'h0900_0200);
        mem[18] = 32'hA000_0001; mem[19] = 32'hA000_0002; mem[20] = 32'hA000_0003;
        mem[21] = 32'hFFFF_FFFF;
        put(22, 32'h0000_00A5, 32'h01F0_0300);
        put(24, 32'd2, 32'h0900_0200);
        mem[26] = 32'hB000_0001; mem[27] = 32'hB000_0002;
        put(28, 32'd0, 32'h0900_0200);
        put(30, 32'h0000_5A5A, 32'h01F0_0301);
        expect_wr(20'h00200, 4'hF, 32'hA000_0001);
        expect_wr(20'h00200, 4'hF, 32'hA000_0002);
        expect_wr(20'h00200, 4'hF, 32'hA000_0003);
        expect_wr(20'h00300, 4'hF, 32'h0000_00A5);
        expect_wr(20'h00200, 4'hF, 32'hB000_0001);
        expect_wr(20'h00200, 4'hF, 32'hB000_0002);
        expect_wr(20'h00301, 4'hF, 32'h0000_5A5A);
        start(16, 32, 1);
        finish_run(32, "burst R4");

        // R6 microsecond wait of 3 ticks
        put(40, 32'h1, 32'h01F0_0010);
        put(42, 32'd3, 32'h0200_0000);
        put(44, 32'h2, 32'h01F0_0011);
        expect_wr(20'h00010, 4'hF, 32'h1);
        expect_wr(20'h00011, 4'hF, 32'h2);
        clear_stamps();
        start(40, 46, 1);
        finish_run(46, "wait_us");
        if (wr_tick_q.size() == 2) begin
            chk(wr_tick_q[1] - wr_tick_q[0] >= 3, "R6 ticks elapsed >= 3", wr_tick_q[1] - wr_tick_q[0], 3);
        end else chk(0, "R6 two writes", wr_tick_q.size(), 2);

        // R6 zero wait adds no delay
        put(48, 32'h3, 32'h01F0_0012);
        put(50, 32'd0, 32'h0200_0000);
        put(52, 32'h4, 32'h01F0_0013);
        expect_wr(20'h00012, 4'hF, 32'h3);
        expect_wr(20'h00013, 4'hF, 32'h4);
        clear_stamps();
        start(48, 54, 1);
        finish_run(54, "wait0");
        if (wr_cyc_q.size() == 2) begin
            chk(wr_cyc_q[1] - wr_cyc_q[0] <= 8, "R6 zero wait cycles", wr_cyc_q[1] - wr_cyc_q[0], 8);
        end else chk(0, "R6 two writes (zero)", wr_cyc_q.size(), 2);

        // R7 vblank wait of 2
        put(56, 32'h5, 32'h01F0_0020);
        put(58, 32'd2, 32'h0400_0000);
        put(60, 32'h6, 32'h01F0_0021);
        expect_wr(20'h00020, 4'hF, 32'h5);
        expect_wr(20'h00021, 4'hF, 32'h6);
        clear_stamps();
        start(56, 62, 1);
        finish_run(62, "wait_vb");
        if (wr_vb_q.size() == 2) begin
            chk(wr_vb_q[1] - wr_vb_q[0] >= 2, "R7 blanks elapsed >= 2", wr_vb_q[1] - wr_vb_q[0], 2);
        end else chk(0, "R7 two writes", wr_vb_q.size(), 2);

        // R8 interrupt and clear
        put(64, 32'h0, 32'h0700_0000);
        start(64, 66, 1);
        finish_run(66, "irq");
        chk(prog_done, "R8 prog_done set", prog_done, 1);
        repeat (5) @(negedge clk);
        chk(prog_done, "R8 prog_done sticky", prog_done, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(!prog_done, "R8 prog_done cleared", prog_done, 0);

        // R9 companion handshake
        exp_xop = 8'h05; exp_xlo = 32'h0064_0032; exp_xhi = 24'h000ABC;
        put(72, 32'h0064_0032, 32'h0500_0ABC);
        put(74, 32'h7, 32'h01F0_0030);
        expect_wr(20'h00030, 4'hF, 32'h7);
        clear_stamps();
        start(72, 76, 1);
        finish_run(76, "ext");
        chk(ext_seen == 1, "R9 one start pulse", ext_seen, 1);
        if (wr_cyc_q.size() == 1) begin
            chk(wr_cyc_q[0] > done_cyc, "R9 write after done", wr_cyc_q[0], done_cyc);
        end else chk(0, "R9 write count", wr_cyc_q.size(), 1);

        // R10 unknown opcode
        chk(!err_flag, "R10 err clear before", err_flag, 0);
        put(80, 32'h0, 32'h5500_0000);
        put(82, 32'h8, 32'h01F0_0040);
        expect_wr(20'h00040, 4'hF, 32'h8);
        start(80, 84, 1);
        finish_run(84, "bad op");
        chk(err_flag, "R10 err set", err_flag, 1);

        // R2 enable low and head equal to tail
        put(88, 32'h9, 32'h01F0_0050);
        start(88, 90, 0);
        repeat (10) @(negedge clk);
        chk(!busy, "R2 disabled start ignored", busy, 0);
        chk(fetch_ptr == AW'(84), "R2 pointer unchanged", fetch_ptr, 84);
        start(88, 88, 1);
        repeat (10) @(negedge clk);
        chk(!busy, "R2 empty program no run", busy, 0);

        // R12 halt during a long wait
        put(96, 32'd1000, 32'h0200_0000);
        put(98, 32'hA, 32'h01F0_0060);
        start(96, 100, 1);
        repeat (20) @(negedge clk);
        chk(busy, "R12 busy in wait", busy, 1);
        ctl_halt = 1'b1;
        @(negedge clk);
        ctl_halt = 1'b0;
        chk(!busy, "R12 busy low after halt", busy, 0);
        repeat (200) @(negedge clk);
        chk(!busy, "R12 stays idle", busy, 0);
        chk(exp_q.size() == 0, "R12 no writes", exp_q.size(), 0);
        chk(err_flag, "R10 err sticky", err_flag, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule